// File: doc/BRIEF.md
# HyperBus Pseudo-Static RAM Transaction Controller

This block is the host side of a HyperBus link to a pseudo-static RAM. It runs one read or one write burst at a time and is built for low latency. A user request names the direction, the space (device register or memory array), a 16-bit word address and a word count. The controller then drives the whole transaction on the bus. Chip select goes low. Three clocks carry the 48-bit command/address word. During those clocks the controller listens to RWDS to learn whether the memory wants one or two latency periods. Write data then goes out, or captured read words are passed through. Last, the bus clock is stopped and chip select is released.

The DDR pads, shifted clocks and RWDS strobe alignment are not part of this block. Each bus clock is shown as one controller clock. The 16-bit DQ value holds the rising-edge byte in bits 15:8 and the falling-edge byte in bits 7:0, and `bus_ck_en` gates the bus clock for that cycle. The request and write-data ports use valid/ready. The request port is ready only in idle. The write port applies back-pressure by holding `wr_ready` low outside the data phase. When the user stalls the write port, the bus clock stops for that cycle. Read data has no ready: each word is offered for exactly the one cycle in which the capture path flags it, and the consumer must take it then.

Top module: `hbus_xact_ctrl`

## Requirements
- R1: After a request handshake, chip select is low for three consecutive clocks with bus clock on and DQ driven. In those clocks DQ carries the command/address word as bits 47:32, then 31:16, then 15:0.
- R2: Command/address layout: bit 47 = 1 for a read and 0 for a write. Bit 46 = 1 for register space. Bit 45 = 1 (linear burst). Bits 44:16 = word address shifted right by 3. Bits 2:0 = word address bits 2:0. All other bits are 0.
- R3: For a memory write, RWDS is sampled in the third command/address clock. If it is low, exactly `cfg_latency` clocks follow with chip select low, DQ undriven and `wr_ready` low. If it is high, twice that many clocks follow.
- R4: When `cfg_fixed_double` is 1, a memory write always waits 2×`cfg_latency` clocks, whatever RWDS shows.
- R5: In the write data phase, `wr_ready` is 1. Each accepted word is driven on DQ that clock, with the bus clock on. `bus_rwds_o` is the inverse of `wr_be`, where 1 means masked, and `bus_rwds_oe` is 1. A clock with `wr_valid` low has the bus clock off. The phase ends after `req_len` words.
- R6: A register write puts its single data word in the clock right after the command/address, with no latency wait even when RWDS was high. It sends exactly one word and leaves RWDS undriven.
- R7: A read enters its data phase right after the command/address, whatever RWDS showed. `rd_valid`/`rd_data` follow `cap_valid`/`cap_data` in the same clock. DQ and RWDS are undriven. The read ends after `req_len` words.
- R8: A transaction ends with one clock in which chip select is low and the bus clock is off, with `done` high for that clock. Chip select goes high in the next clock.
- R9: After chip select rises, it stays high and `busy` stays 1 with `req_ready` 0 for `RECOV_CLKS` clocks. Then `req_ready` returns to 1.
- R10: A request is rejected if its length is 0 or above `MAX_WORDS`, or if address plus length exceeds 2^`ADDR_W`. A rejected request is accepted by handshake, `err_reject` pulses one clock later, and chip select stays high.
- R11: If a read sees `RD_TIMEOUT` clocks in a row with no valid word, the transaction ends through the R8 stop clock with `err_timeout` high in place of `done`.
- R12: After reset, chip select is high, the bus clock is off, DQ and RWDS are undriven, `busy` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one per bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_latency | input | LAT_W | Latency period in clocks (1 or more) |
| cfg_fixed_double | input | 1 | Always wait two latency periods |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this clock |
| req_read | input | 1 | 1 = read, 0 = write |
| req_reg | input | 1 | 1 = register space |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Word count |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word taken |
| wr_data | input | 16 | Write word, bits 15:8 on the rising edge |
| wr_be | input | 2 | Byte enables, 1 = write that byte |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 16 | Read word |
| done | output | 1 | Transaction completed (stop clock) |
| err_reject | output | 1 | Request rejected |
| err_timeout | output | 1 | Read ended by timeout |
| busy | output | 1 | Transaction or recovery in progress |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ck_en | output | 1 | Bus clock enable for this cycle |
| bus_dq_o | output | 16 | DQ byte pair (rise, fall) |
| bus_dq_oe | output | 1 | DQ output enable |
| bus_rwds_o | output | 2 | RWDS pair (rise, fall) |
| bus_rwds_oe | output | 1 | RWDS output enable |
| bus_rwds_i | input | 1 | RWDS level from the memory |
| cap_valid | input | 1 | Captured read word valid |
| cap_data | input | 16 | Captured read word |

## Verification
The first command/address word is due in the clock right after the handshake edge. The data phase is due exactly 0, L or 2L clocks after the third command/address clock. `rd_valid` is due in the same clock as `cap_valid`. `err_reject` is due one clock after the handshake, the stop clock one clock after the last word, and `req_ready` `RECOV_CLKS` clocks after that. The bench drives inputs at the falling edge and samples 1 ns later, walking through each transaction clock by clock. So every cycle of the expected sequence is compared, not just its end. Random stalls and read gaps shift those due times, and the bench tracks them by stepping the same clocks it inserts.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CA,
    ST_LAT,
    ST_WDATA,
    ST_RDATA,
    ST_STOP,
    ST_RECOV
  } hb_state_e;

  localparam int CA_BITS = 48;
endpackage

// File: rtl/hbus_ca_build.sv
module hbus_ca_build #(
  parameter int ADDR_W = 22
) (
  input  logic                          is_read,
  input  logic                          is_reg,
  input  logic [ADDR_W-1:0]             word_addr,
  output logic [hbus_pkg::CA_BITS-1:0]  ca
);
  // Upper address part goes to bits 44:16, the low three bits to 2:0.
  always_comb begin
    ca        = '0;
    ca[47]    = is_read;
    ca[46]    = is_reg;
    ca[45]    = 1'b1;
    ca[44:16] = 29'(word_addr >> 3);
    ca[2:0]   = word_addr[2:0];
  end
endmodule

// File: rtl/hbus_req_check.sv
module hbus_req_check #(
  parameter int ADDR_W    = 22,
  parameter int LEN_W     = 9,
  parameter int MAX_WORDS = 128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              ok
);
  localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  logic [SUM_W-1:0] end_w;
  logic [SUM_W-1:0] top_w;

  always_comb begin
    end_w = SUM_W'(addr) + SUM_W'(len);
    top_w = SUM_W'(1) << ADDR_W;
    ok    = (len != '0) && (len <= LEN_W'(MAX_WORDS)) && (end_w <= top_w);
  end
endmodule

// File: rtl/hbus_xact_ctrl.sv
module hbus_xact_ctrl #(
  parameter int ADDR_W     = 22,
  parameter int LEN_W      = 9,
  parameter int MAX_WORDS  = 128,
  parameter int LAT_W      = 4,
  parameter int RECOV_CLKS = 4,
  parameter int RD_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic              cfg_fixed_double,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_reg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [15:0]       wr_data,
  input  logic [1:0]        wr_be,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              done,
  output logic              err_reject,
  output logic              err_timeout,
  output logic              busy,
  output logic              bus_cs_n,
  output logic              bus_ck_en,
  output logic [15:0]       bus_dq_o,
  output logic              bus_dq_oe,
  output logic [1:0]        bus_rwds_o,
  output logic              bus_rwds_oe,
  input  logic              bus_rwds_i,
  input  logic              cap_valid,
  input  logic [15:0]       cap_data
);
  import hbus_pkg::*;

  localparam int TMO_W = $clog2(RD_TIMEOUT + 1);
  localparam int REC_W = $clog2(RECOV_CLKS + 1);
  localparam int CHK_W = REC_W + 1;

  hb_state_e            state;
  logic [CA_BITS-1:0]   ca_next, ca_q;
  logic                 req_ok;
  logic                 is_read_q, is_reg_q, tmo_q, rej_q;
  logic [LEN_W-1:0]     len_q, word_cnt;
  logic [1:0]           ca_cnt;
  logic [LAT_W:0]       lat_total, lat_cnt;
  logic [TMO_W-1:0]     tmo_cnt;
  logic [REC_W-1:0]     rec_cnt;

  hbus_ca_build #(.ADDR_W(ADDR_W)) ca_i (
    .is_read   (req_read),
    .is_reg    (req_reg),
    .word_addr (req_addr),
    .ca        (ca_next)
  );

  hbus_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS)) chk_i (
    .addr (req_addr),
    .len  (req_len),
    .ok   (req_ok)
  );

  // One or two latency periods, decided by RWDS or forced double mode.
  always_comb begin
    if (cfg_fixed_double || bus_rwds_i) lat_total = {cfg_latency, 1'b0};
    else                                lat_total = {1'b0, cfg_latency};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ca_q      <= '0;
      is_read_q <= 1'b0;
      is_reg_q  <= 1'b0;
      tmo_q     <= 1'b0;
      rej_q     <= 1'b0;
      len_q     <= '0;
      word_cnt  <= '0;
      ca_cnt    <= '0;
      lat_cnt   <= '0;
      tmo_cnt   <= '0;
      rec_cnt   <= '0;
    end else begin
      rej_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          if (req_ok) begin
            ca_q      <= ca_next;
            is_read_q <= req_read;
            is_reg_q  <= req_reg;
            len_q     <= (req_reg && !req_read) ? LEN_W'(1) : req_len;
            ca_cnt    <= '0;
            word_cnt  <= '0;
            tmo_cnt   <= '0;
            state     <= ST_CA;
          end else begin
            rej_q <= 1'b1;
          end
        end
        ST_CA: begin
          ca_cnt <= ca_cnt + 2'd1;
          if (ca_cnt == 2'd2) begin
            if (is_read_q)     state <= ST_RDATA;
            else if (is_reg_q) state <= ST_WDATA;
            else begin
              lat_cnt <= lat_total - 1'b1;
              state   <= ST_LAT;
            end
          end
        end
        ST_LAT: begin
          if (lat_cnt == '0) state <= ST_WDATA;
          else               lat_cnt <= lat_cnt - 1'b1;
        end
        ST_WDATA: if (wr_valid) begin
          word_cnt <= word_cnt + LEN_W'(1);
          if (word_cnt == len_q - LEN_W'(1)) begin
            tmo_q <= 1'b0;
            state <= ST_STOP;
          end
        end
        ST_RDATA: begin
          if (cap_valid) begin
            tmo_cnt  <= '0;
            word_cnt <= word_cnt + LEN_W'(1);
            if (word_cnt == len_q - LEN_W'(1)) begin
              tmo_q <= 1'b0;
              state <= ST_STOP;
            end
          end else if (tmo_cnt == TMO_W'(RD_TIMEOUT - 1)) begin
            tmo_q <= 1'b1;
            state <= ST_STOP;
          end else begin
            tmo_cnt <= tmo_cnt + TMO_W'(1);
          end
        end
        ST_STOP: begin
          rec_cnt <= '0;
          state   <= ST_RECOV;
        end
        ST_RECOV: begin
          if (rec_cnt == REC_W'(RECOV_CLKS - 1)) state <= ST_IDLE;
          else                                    rec_cnt <= rec_cnt + REC_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_cs_n    = !(state inside {ST_CA, ST_LAT, ST_WDATA, ST_RDATA, ST_STOP});
    bus_ck_en   = (state inside {ST_CA, ST_LAT, ST_RDATA}) || (state == ST_WDATA && wr_valid);
    bus_dq_oe   = (state == ST_CA) || (state == ST_WDATA && wr_valid);
    bus_dq_o    = '0;
    if (state == ST_CA) begin
      case (ca_cnt)
        2'd0:    bus_dq_o = ca_q[47:32];
        2'd1:    bus_dq_o = ca_q[31:16];
        default: bus_dq_o = ca_q[15:0];
      endcase
    end else if (state == ST_WDATA) begin
      bus_dq_o = wr_data;
    end
    bus_rwds_oe = (state == ST_WDATA) && !is_reg_q;
    bus_rwds_o  = bus_rwds_oe ? ~wr_be : 2'b00;
    wr_ready    = (state == ST_WDATA);
    rd_valid    = (state == ST_RDATA) && cap_valid;
    rd_data     = cap_data;
    done        = (state == ST_STOP) && !tmo_q;
    err_timeout = (state == ST_STOP) && tmo_q;
    err_reject  = rej_q;
    busy        = (state != ST_IDLE);
    req_ready   = (state == ST_IDLE);
  end

  // Checker counter: clocks of chip select high, saturating.
  logic [CHK_W-1:0] cs_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cs_hi_cnt <= CHK_W'(RECOV_CLKS);
    else if (!bus_cs_n)                       cs_hi_cnt <= '0;
    else if (cs_hi_cnt < CHK_W'(RECOV_CLKS))  cs_hi_cnt <= cs_hi_cnt + CHK_W'(1);
  end

  assert_cs_recovery_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> cs_hi_cnt >= CHK_W'(RECOV_CLKS));
  assert_busy_after_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> busy);
  assert_ck_needs_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ck_en |-> !bus_cs_n);
  assert_clk_stops_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> !$past(bus_ck_en));
  assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_reject |-> bus_cs_n);
  assert_read_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!bus_dq_oe && !bus_rwds_oe));
  assert_timeout_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (!bus_ck_en && !bus_cs_n && !done));
endmodule

// File: tb/hbus_xact_ctrl_tb_top.sv
module hbus_xact_ctrl_tb_top;
  localparam int ADDR_W = 10, LEN_W = 6, MAX_WORDS = 16, LAT_W = 4;
  localparam int RECOV_CLKS = 3, RD_TIMEOUT = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LAT_W-1:0] cfg_latency = 4'd3;
  logic cfg_fixed_double = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, req_reg = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0] wr_be = '0;
  logic bus_rwds_i = 1'b0, cap_valid = 1'b0;
  logic [15:0] cap_data = '0;
  logic req_ready, wr_ready, rd_valid, done, err_reject, err_timeout, busy;
  logic bus_cs_n, bus_ck_en, bus_dq_oe, bus_rwds_oe;
  logic [15:0] rd_data, bus_dq_o;
  logic [1:0] bus_rwds_o;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hbus_xact_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS), .LAT_W(LAT_W),
                   .RECOV_CLKS(RECOV_CLKS), .RD_TIMEOUT(RD_TIMEOUT)) dut_i (
    .clk, .rst_n, .cfg_latency, .cfg_fixed_double, .req_valid, .req_ready, .req_read,
    .req_reg, .req_addr, .req_len, .wr_valid, .wr_ready, .wr_data, .wr_be, .rd_valid,
    .rd_data, .done, .err_reject, .err_timeout, .busy, .bus_cs_n, .bus_ck_en, .bus_dq_o,
    .bus_dq_oe, .bus_rwds_o, .bus_rwds_oe, .bus_rwds_i, .cap_valid, .cap_data);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [47:0] ca_exp(input bit rd, input bit rg, input int unsigned a);
    logic [47:0] c = '0;
    c[47] = rd; c[46] = rg; c[45] = 1'b1;
    c[44:16] = 29'(a / 8);
    c[2:0] = 3'(a % 8);
    return c;
  endfunction

  function automatic bit fits(input int unsigned a, input int unsigned n);
    return (n >= 1) && (n <= MAX_WORDS) && (a + n <= (1 << ADDR_W));
  endfunction

  // Handshake plus the three command/address clocks (R1, R2).
  task automatic start_req(input bit rd, input bit rg, input int unsigned a,
                           input int unsigned n, input bit rw_hi);
    logic [47:0] c = ca_exp(rd, rg, a);
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_reg = rg;
    req_addr = ADDR_W'(a); req_len = LEN_W'(n);
    #1 chk("R9 ready in idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0; bus_rwds_i = rw_hi;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R1 cs low", bus_cs_n, 0);
      chk("R1 ck on", bus_ck_en, 1);
      chk("R1 dq oe", bus_dq_oe, 1);
      chk("R2 ca word", bus_dq_o, (i == 0) ? c[47:32] : (i == 1) ? c[31:16] : c[15:0]);
      @(negedge clk);
    end
    bus_rwds_i = 1'b0;
  endtask

  task automatic finish_xact(input bit timed_out);
    #1;
    chk("R8 stop cs low", bus_cs_n, 0);
    chk("R8 stop ck off", bus_ck_en, 0);
    chk(timed_out ? "R11 timeout flag" : "R8 done", timed_out ? err_timeout : done, 1);
    @(negedge clk);
    for (int i = 0; i < RECOV_CLKS; i++) begin
      #1;
      chk("R9 cs high", bus_cs_n, 1);
      chk("R9 busy", busy, 1);
      chk("R9 not ready", req_ready, 0);
      @(negedge clk);
    end
    #1 chk("R9 ready again", req_ready, 1);
  endtask

  task automatic do_write(input bit rg, input int unsigned a, input int unsigned n,
                          input bit rw_hi, input bit fixd, input int unsigned lat);
    int unsigned wait_n, words;
    cfg_latency = LAT_W'(lat); cfg_fixed_double = fixd;
    start_req(1'b0, rg, a, n, rw_hi);
    wait_n = rg ? 0 : ((fixd || rw_hi) ? 2 * lat : lat);
    for (int i = 0; i < wait_n; i++) begin
      #1;
      chk(fixd ? "R4 latency cs" : "R3 latency cs", bus_cs_n, 0);
      chk(fixd ? "R4 latency no data" : "R3 latency no data", {bus_dq_oe, wr_ready}, 0);
      @(negedge clk);
    end
    words = rg ? 1 : n;
    for (int k = 0; k < words; k++) begin
      if ($urandom % 4 == 0) begin
        wr_valid = 1'b0;
        #1 chk("R5 stall stops clock", bus_ck_en, 0);
        @(negedge clk);
      end
      wr_valid = 1'b1; wr_data = 16'($urandom); wr_be = 2'($urandom);
      #1;
      chk(rg ? "R6 reg word ready" : "R5 wr_ready", wr_ready, 1);
      chk(rg ? "R6 reg word dq" : "R5 dq data", {bus_dq_oe, bus_ck_en, bus_dq_o}, {2'b11, wr_data});
      chk(rg ? "R6 rwds undriven" : "R5 rwds mask", {bus_rwds_oe, bus_rwds_o},
          rg ? 3'b000 : {1'b1, ~wr_be});
      @(negedge clk);
    end
    wr_valid = 1'b0;
    finish_xact(1'b0);
  endtask

  task automatic do_read(input bit rg, input int unsigned a, input int unsigned n,
                         input bit rw_hi, input int unsigned give);
    start_req(1'b1, rg, a, n, rw_hi);
    for (int k = 0; k < n; k++) begin
      if (k == give) begin
        for (int t = 0; t < RD_TIMEOUT; t++) begin
          cap_valid = 1'b0;
          #1 chk("R11 waiting", {bus_cs_n, bus_ck_en, rd_valid}, 3'b010);
          @(negedge clk);
        end
        finish_xact(1'b1);
        return;
      end
      if (k != 0 && $urandom % 3 == 0) begin
        cap_valid = 1'b0;
        #1 chk("R7 gap", {rd_valid, bus_ck_en, bus_dq_oe}, 3'b010);
        @(negedge clk);
      end
      cap_valid = 1'b1; cap_data = 16'($urandom);
      #1;
      chk("R7 rd_valid", rd_valid, 1);
      chk("R7 rd_data", rd_data, cap_data);
      chk("R7 bus undriven", {bus_dq_oe, bus_rwds_oe}, 0);
      @(negedge clk);
    end
    cap_valid = 1'b0;
    finish_xact(1'b0);
  endtask

  task automatic do_reject(input int unsigned a, input int unsigned n);
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'($urandom); req_reg = 1'b0;
    req_addr = ADDR_W'(a); req_len = LEN_W'(n);
    #1 chk("R10 handshake", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R10 reject pulse", err_reject, 1);
    chk("R10 cs stays high", bus_cs_n, 1);
    @(negedge clk);
    #1 chk("R10 idle after", {err_reject, busy, bus_cs_n}, 3'b001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset cs", bus_cs_n, 1);
    chk("R12 reset ck", bus_ck_en, 0);
    chk("R12 reset oe", {bus_dq_oe, bus_rwds_oe}, 0);
    chk("R12 reset busy/ready", {busy, req_ready}, 2'b01);
    rst_n = 1'b1;

    do_write(1'b0, 40, 4, 1'b0, 1'b0, 3);   // R3 single period
    do_write(1'b0, 9, 3, 1'b1, 1'b0, 3);    // R3 double period
    do_write(1'b0, 100, 2, 1'b0, 1'b1, 2);  // R4 forced double
    do_write(1'b1, 1, 5, 1'b1, 1'b0, 4);    // R6 register write
    do_read(1'b0, 517, 6, 1'b1, 99);        // R7 no latency on reads
    do_read(1'b1, 0, 1, 1'b0, 99);          // R7 register read
    do_read(1'b0, 1016, 8, 1'b0, 99);       // R10 boundary accepted
    do_read(1'b0, 64, 5, 1'b0, 2);          // R11 timeout after 2 words
    do_reject(12, 0);                       // R10 zero length
    do_reject(12, MAX_WORDS + 1);           // R10 too long
    do_reject(1020, 5);                     // R10 past top

    for (int it = 0; it < 40; it++) begin
      int unsigned a = $urandom % (1 << ADDR_W);
      int unsigned n = $urandom % (MAX_WORDS + 2);
      if (!fits(a, n)) do_reject(a, n);
      else if ($urandom % 2 == 0)
        do_write(1'b0, a, n, 1'($urandom), 1'($urandom), 1 + $urandom % 4);
      else
        do_read(1'b0, a, n, 1'($urandom), ($urandom % 5 == 0) ? $urandom % n : 99);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule